// File: doc/BRIEF.md
# On-Demand Configuration Fetch Engine

This engine sits beside a processing resource. It guarantees that a configuration is present in the resource's local configuration memory before the resource uses it. That local memory is split into equal slots. A descriptor table records which configuration id, if any, each slot holds. When a lookup finds the id, the engine returns the slot number in the next cycle.

When the lookup misses, the engine picks a victim slot and clears its descriptor. It then fetches the configuration from a remote configuration server, one block at a time. Each move request carries a remote source block index and a local destination base address. The server answers with a header word that holds the destination address, followed by a fixed number of data words. The engine writes those words straight into local memory at consecutive addresses. After the final word of the final block, the engine marks the slot valid and reports it.

Only one move request is ever outstanding, and no new lookup is accepted while a fetch runs. The number of blocks in a configuration is derived from its id: (id mod MAX_BLKS) + 1.

Top module: `cfg_fetch_engine`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `done_valid`, `pkt_valid` and `cw_en` are 0, and every slot is empty.
- R2: A lookup accepted (`req_valid` and `req_ready`) for a resident id raises `done_valid` with that slot on `done_slot` in the following cycle. No move request is issued.
- R3: The first move request of a miss appears in the cycle after acceptance. It has `pkt_src` = id*MAX_BLKS and `pkt_dst` = slot*SLOT_WORDS, where SLOT_WORDS = BLK_WORDS*MAX_BLKS.
- R4: In a response, the low ADDR_W bits of the first valid word give the start address. The next BLK_WORDS valid words appear on the write port unchanged, at that address and the ones after it. Cycles with `resp_valid` low write nothing.
- R5: Each later move request of the same fetch has a source one higher and a destination BLK_WORDS higher than the previous one. A fetch issues exactly (id mod MAX_BLKS)+1 requests.
- R6: A move request is issued only after the last data word of the previous block has been written. `req_ready` stays low from a miss acceptance until its completion, and `req_valid` is ignored during that time.
- R7: A fetch completes with a one-cycle `done_valid` pulse carrying the filled slot, one cycle after its final data word is written. From then on, a lookup of that id hits.
- R8: On a miss, the victim is the lowest-numbered empty slot when one exists.
- R9: When no slot is empty, the victim comes from a round-robin pointer. The pointer resets to 0, is bumped past the slot most recently reported on `done_slot`, and moves to one past the victim after each eviction. An evicted id misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_id | input | ID_W | Configuration id to make resident |
| req_ready | output | 1 | Engine idle, lookup accepted this cycle if valid |
| done_valid | output | 1 | One-cycle pulse: configuration resident |
| done_slot | output | SLOT_W | Slot holding the configuration |
| pkt_valid | output | 1 | Move request to the remote server |
| pkt_src | output | SRC_W | Remote source block index |
| pkt_dst | output | ADDR_W | Local destination base address |
| resp_valid | input | 1 | Response word valid |
| resp_data | input | DATA_W | Header word, then data words |
| cw_en | output | 1 | Local configuration memory write enable |
| cw_addr | output | ADDR_W | Local write address |
| cw_data | output | DATA_W | Local write data |

## Verification
The hardest state to reach is a full table where the round-robin pointer lands exactly on the slot most recently returned. That slot must be skipped. The stimulus gets there in three steps: it fills all slots with ids of differing lengths, it evicts its way round the pointer, and it then hits a slot chosen so that the next miss starts on it. A second difficult case is a lookup that arrives while a fetch is waiting for a response header. The bench raises `req_valid` for a resident id during that gap and checks that no extra completion or move request follows. Responses arrive with idle cycles before the header and bubbles between data words.

// File: rtl/cfgf_pkg.sv
package cfgf_pkg;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_SEND,
        FS_HDR,
        FS_DATA
    } fetch_state_e;

    // Length of a configuration in blocks, derived from its id.
    function automatic int unsigned blocks_for_id(input int unsigned id,
                                                  input int unsigned max_blks);
        return (id % max_blks) + 1;
    endfunction

endpackage

// File: rtl/cfgf_desc_tab.sv
module cfgf_desc_tab #(
    parameter int NUM_SLOTS = 4,
    parameter int ID_W      = 4,
    parameter int SLOT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ID_W-1:0]      look_id,
    input  logic                 clr_en,
    input  logic [SLOT_W-1:0]    clr_slot,
    input  logic                 set_en,
    input  logic [SLOT_W-1:0]    set_slot,
    input  logic [ID_W-1:0]      set_id,
    output logic                 hit,
    output logic [SLOT_W-1:0]    hit_slot,
    output logic [NUM_SLOTS-1:0] empty_vec
);
    logic [NUM_SLOTS-1:0] match;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic            occ;
        logic [ID_W-1:0] tag;

        always_ff @(posedge clk) begin
            if (rst) begin
                occ <= 1'b0;
                tag <= '0;
            end else if (set_en && set_slot == SLOT_W'(g)) begin
                occ <= 1'b1;
                tag <= set_id;
            end else if (clr_en && clr_slot == SLOT_W'(g)) begin
                occ <= 1'b0;
            end
        end

        assign match[g]     = occ && (tag == look_id);
        assign empty_vec[g] = !occ;
    end

    assign hit = |match;

    always_comb begin
        hit_slot = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (match[i]) hit_slot = SLOT_W'(i);
        end
    end

endmodule

// File: rtl/cfgf_victim.sv
module cfgf_victim #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] empty_vec,
    input  logic                 act_valid,
    input  logic [SLOT_W-1:0]    act_slot,
    input  logic                 take,
    output logic [SLOT_W-1:0]    victim
);
    logic [SLOT_W-1:0] rr_q;
    logic [SLOT_W-1:0] rr_pick;
    logic [SLOT_W-1:0] first_empty;
    logic              have_empty;

    function automatic logic [SLOT_W-1:0] step(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(NUM_SLOTS - 1)) ? '0 : s + 1'b1;
    endfunction

    always_comb begin
        first_empty = '0;
        have_empty  = |empty_vec;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (empty_vec[i]) first_empty = SLOT_W'(i);
        end
        rr_pick = (act_valid && rr_q == act_slot) ? step(rr_q) : rr_q;
        victim  = have_empty ? first_empty : rr_pick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (take && !have_empty) begin
            rr_q <= step(victim);
        end
    end

    AST_VICTIM_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (take && act_valid) |-> (victim != act_slot)); // R9

    AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (rst)
        (take && have_empty) |-> empty_vec[victim]); // R8

endmodule

// File: rtl/cfgf_seq.sv
module cfgf_seq
    import cfgf_pkg::*;
#(
    parameter int ID_W      = 4,
    parameter int SLOT_W    = 2,
    parameter int DATA_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int MAX_BLKS  = 4,
    parameter int ADDR_W    = 6,
    parameter int SRC_W     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    output logic              req_ready,
    input  logic              hit,
    input  logic [SLOT_W-1:0] hit_slot,
    input  logic [SLOT_W-1:0] victim,
    output logic              clr_en,
    output logic              take,
    output logic              set_en,
    output logic [SLOT_W-1:0] set_slot,
    output logic [ID_W-1:0]   set_id,
    output logic              act_valid,
    output logic [SLOT_W-1:0] act_slot,
    output logic              done_valid,
    output logic [SLOT_W-1:0] done_slot,
    output logic              pkt_valid,
    output logic [SRC_W-1:0]  pkt_src,
    output logic [ADDR_W-1:0] pkt_dst,
    input  logic              resp_valid,
    input  logic [DATA_W-1:0] resp_data,
    output logic              cw_en,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [DATA_W-1:0] cw_data
);
    localparam int BIDX_W  = $clog2(MAX_BLKS);
    localparam int BCNT_W  = BIDX_W + 1;
    localparam int WCNT_W  = $clog2(BLK_WORDS);
    localparam int OFF_W   = ADDR_W - SLOT_W;

    fetch_state_e      st_q;
    logic [ID_W-1:0]   id_q;
    logic [SLOT_W-1:0] slot_q;
    logic [BCNT_W-1:0] bidx_q;
    logic [BCNT_W-1:0] btot_q;
    logic [SRC_W-1:0]  src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [WCNT_W-1:0] wcnt_q;

    logic accept;
    logic last_word;
    logic last_blk;

    assign req_ready = (st_q == FS_IDLE);
    assign accept    = req_ready && req_valid;
    assign clr_en    = accept && !hit;
    assign take      = clr_en;

    assign pkt_valid = (st_q == FS_SEND);
    assign pkt_src   = src_q;
    assign pkt_dst   = dst_q;

    assign cw_en     = (st_q == FS_DATA) && resp_valid;
    assign cw_addr   = waddr_q;
    assign cw_data   = resp_data;

    assign last_word = (wcnt_q == WCNT_W'(BLK_WORDS - 1));
    assign last_blk  = (bidx_q == btot_q - 1'b1);
    assign set_en    = cw_en && last_word && last_blk;
    assign set_slot  = slot_q;
    assign set_id    = id_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= FS_IDLE;
            id_q       <= '0;
            slot_q     <= '0;
            bidx_q     <= '0;
            btot_q     <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            waddr_q    <= '0;
            wcnt_q     <= '0;
            done_valid <= 1'b0;
            done_slot  <= '0;
            act_valid  <= 1'b0;
            act_slot   <= '0;
        end else begin
            done_valid <= 1'b0;
            unique case (st_q)
                FS_IDLE: begin
                    if (accept && hit) begin
                        done_valid <= 1'b1;
                        done_slot  <= hit_slot;
                        act_valid  <= 1'b1;
                        act_slot   <= hit_slot;
                    end else if (accept) begin
                        id_q   <= req_id;
                        slot_q <= victim;
                        bidx_q <= '0;
                        btot_q <= BCNT_W'(blocks_for_id(32'(req_id), MAX_BLKS));
                        src_q  <= {req_id, BIDX_W'(0)};
                        dst_q  <= {victim, OFF_W'(0)};
                        st_q   <= FS_SEND;
                    end
                end
                FS_SEND: st_q <= FS_HDR;
                FS_HDR: begin
                    if (resp_valid) begin
                        waddr_q <= resp_data[ADDR_W-1:0];
                        wcnt_q  <= '0;
                        st_q    <= FS_DATA;
                    end
                end
                FS_DATA: begin
                    if (resp_valid) begin
                        waddr_q <= waddr_q + 1'b1;
                        wcnt_q  <= wcnt_q + 1'b1;
                        if (last_word && last_blk) begin
                            done_valid <= 1'b1;
                            done_slot  <= slot_q;
                            act_valid  <= 1'b1;
                            act_slot   <= slot_q;
                            st_q       <= FS_IDLE;
                        end else if (last_word) begin
                            bidx_q <= bidx_q + 1'b1;
                            src_q  <= src_q + 1'b1;
                            dst_q  <= dst_q + ADDR_W'(BLK_WORDS);
                            st_q   <= FS_SEND;
                        end
                    end
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

    AST_SINGLE_PKT: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> !pkt_valid); // R6

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> !req_ready); // R6

    AST_WRITE_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        cw_en |-> (cw_addr[ADDR_W-1 -: SLOT_W] == slot_q)); // R4

endmodule

// File: rtl/cfg_fetch_engine.sv
module cfg_fetch_engine
    import cfgf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int NUM_SLOTS = 4,
    parameter int BLK_WORDS = 4,
    parameter int MAX_BLKS  = 4,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int SLOT_WORDS = BLK_WORDS * MAX_BLKS,
    localparam int ADDR_W     = SLOT_W + $clog2(SLOT_WORDS),
    localparam int SRC_W      = ID_W + $clog2(MAX_BLKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    output logic              req_ready,
    output logic              done_valid,
    output logic [SLOT_W-1:0] done_slot,
    output logic              pkt_valid,
    output logic [SRC_W-1:0]  pkt_src,
    output logic [ADDR_W-1:0] pkt_dst,
    input  logic              resp_valid,
    input  logic [DATA_W-1:0] resp_data,
    output logic              cw_en,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [DATA_W-1:0] cw_data
);
    logic                 tab_hit;
    logic [SLOT_W-1:0]    tab_hit_slot;
    logic [NUM_SLOTS-1:0] tab_empty;
    logic                 clr_en;
    logic                 take;
    logic                 set_en;
    logic [SLOT_W-1:0]    set_slot;
    logic [ID_W-1:0]      set_id;
    logic                 act_valid;
    logic [SLOT_W-1:0]    act_slot;
    logic [SLOT_W-1:0]    victim;

    cfgf_desc_tab #(
        .NUM_SLOTS(NUM_SLOTS),
        .ID_W     (ID_W),
        .SLOT_W   (SLOT_W)
    ) i_tab (
        .clk      (clk),
        .rst      (rst),
        .look_id  (req_id),
        .clr_en   (clr_en),
        .clr_slot (victim),
        .set_en   (set_en),
        .set_slot (set_slot),
        .set_id   (set_id),
        .hit      (tab_hit),
        .hit_slot (tab_hit_slot),
        .empty_vec(tab_empty)
    );

    cfgf_victim #(
        .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W   (SLOT_W)
    ) i_victim (
        .clk      (clk),
        .rst      (rst),
        .empty_vec(tab_empty),
        .act_valid(act_valid),
        .act_slot (act_slot),
        .take     (take),
        .victim   (victim)
    );

    cfgf_seq #(
        .ID_W     (ID_W),
        .SLOT_W   (SLOT_W),
        .DATA_W   (DATA_W),
        .BLK_WORDS(BLK_WORDS),
        .MAX_BLKS (MAX_BLKS),
        .ADDR_W   (ADDR_W),
        .SRC_W    (SRC_W)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_id    (req_id),
        .req_ready (req_ready),
        .hit       (tab_hit),
        .hit_slot  (tab_hit_slot),
        .victim    (victim),
        .clr_en    (clr_en),
        .take      (take),
        .set_en    (set_en),
        .set_slot  (set_slot),
        .set_id    (set_id),
        .act_valid (act_valid),
        .act_slot  (act_slot),
        .done_valid(done_valid),
        .done_slot (done_slot),
        .pkt_valid (pkt_valid),
        .pkt_src   (pkt_src),
        .pkt_dst   (pkt_dst),
        .resp_valid(resp_valid),
        .resp_data (resp_data),
        .cw_en     (cw_en),
        .cw_addr   (cw_addr),
        .cw_data   (cw_data)
    );

    AST_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && tab_hit) |=>
            (done_valid && done_slot == $past(tab_hit_slot) && !pkt_valid)); // R2

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> ($past(cw_en) || $past(req_valid && req_ready && tab_hit))); // R7

endmodule

// File: tb/test_cfg_fetch_engine.sv
`timescale 1ns/100ps
module test_cfg_fetch_engine;
    localparam int DATA_W     = 32;
    localparam int ID_W       = 4;
    localparam int NUM_SLOTS  = 4;
    localparam int BLK_WORDS  = 4;
    localparam int MAX_BLKS   = 4;
    localparam int SLOT_W     = 2;
    localparam int SLOT_WORDS = BLK_WORDS * MAX_BLKS;
    localparam int ADDR_W     = 6;
    localparam int SRC_W      = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ID_W-1:0]   req_id = '0;
    logic              req_ready;
    logic              done_valid;
    logic [SLOT_W-1:0] done_slot;
    logic              pkt_valid;
    logic [SRC_W-1:0]  pkt_src;
    logic [ADDR_W-1:0] pkt_dst;
    logic              resp_valid = 1'b0;
    logic [DATA_W-1:0] resp_data = '0;
    logic              cw_en;
    logic [ADDR_W-1:0] cw_addr;
    logic [DATA_W-1:0] cw_data;

    always #2 clk = ~clk;

    cfg_fetch_engine i_cfg_fetch_engine (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_id(req_id), .req_ready(req_ready),
        .done_valid(done_valid), .done_slot(done_slot),
        .pkt_valid(pkt_valid), .pkt_src(pkt_src), .pkt_dst(pkt_dst),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int mcyc   = 0;

    // reference model state
    int m_occ[NUM_SLOTS];
    int m_id[NUM_SLOTS];
    int m_rr  = 0;
    int m_act = -1;

    // expected events
    int          q_pkt_src[$];
    int          q_pkt_dst[$];
    string       q_pkt_tag[$];
    int          q_wr_addr[$];
    logic [31:0] q_wr_data[$];
    int          q_done_slot[$];
    bit          q_done_miss[$];
    string       q_done_tag[$];
    // observed requests, served by the remote model
    int q_hdr[$];
    int q_rsrc[$];

    int outst   = 0;
    int wleft   = 0;
    int last_wr = -10;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rdata(input int src, input int k);
        return 32'hA500_0000 | 32'(src << 8) | 32'(k);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: samples 1 ns after each falling edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            mcyc++;
            if (pkt_valid) begin
                chk(outst == 0, "R6", "move request while block outstanding", outst, 0);
                if (q_pkt_src.size() == 0) begin
                    chk(1'b0, "R2", "unexpected move request", longint'(pkt_src), 0);
                end else begin
                    int es, ed;
                    string et;
                    es = q_pkt_src.pop_front();
                    ed = q_pkt_dst.pop_front();
                    et = q_pkt_tag.pop_front();
                    chk(int'(pkt_src) == es, et, "pkt_src", longint'(pkt_src), es);
                    chk(int'(pkt_dst) == ed, et, "pkt_dst", longint'(pkt_dst), ed);
                end
                q_hdr.push_back(int'(pkt_dst));
                q_rsrc.push_back(int'(pkt_src));
                outst = 1;
                wleft = BLK_WORDS;
            end
            if (cw_en) begin
                if (q_wr_addr.size() == 0) begin
                    chk(1'b0, "R4", "unexpected write", longint'(cw_addr), 0);
                end else begin
                    int ea;
                    logic [31:0] edt;
                    ea  = q_wr_addr.pop_front();
                    edt = q_wr_data.pop_front();
                    chk(int'(cw_addr) == ea, "R4", "cw_addr", longint'(cw_addr), ea);
                    chk(cw_data == edt, "R4", "cw_data", longint'(cw_data), longint'(edt));
                end
                if (wleft > 0) wleft--;
                if (wleft == 0) outst = 0;
                last_wr = mcyc;
            end
            if (done_valid) begin
                if (q_done_slot.size() == 0) begin
                    chk(1'b0, "R6", "unexpected completion", longint'(done_slot), 0);
                end else begin
                    int es;
                    bit miss;
                    string et;
                    es   = q_done_slot.pop_front();
                    miss = q_done_miss.pop_front();
                    et   = q_done_tag.pop_front();
                    chk(int'(done_slot) == es, et, "done_slot", longint'(done_slot), es);
                    if (miss)
                        chk(mcyc == last_wr + 1, "R7", "done delay after last word",
                            mcyc - last_wr, 1);
                end
            end
        end
    end

    // lookup of one id, with the remote server answering any misses
    task automatic do_req(input int id, input int gap, input int poke);
        int hs;
        hs = -1;
        while (!req_ready) @(negedge clk);
        for (int s = 0; s < NUM_SLOTS; s++)
            if (m_occ[s] != 0 && m_id[s] == id) hs = s;
        if (hs >= 0) begin
            q_done_slot.push_back(hs);
            q_done_miss.push_back(1'b0);
            q_done_tag.push_back("R2");
            m_act = hs;
            req_valid = 1'b1;
            req_id    = ID_W'(id);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(done_valid == 1'b1, "R2", "hit completion next cycle", done_valid, 1);
            chk(pkt_valid == 1'b0, "R2", "no move request on hit", pkt_valid, 0);
            @(negedge clk);
        end else begin
            int v, nb, fe;
            string vt;
            fe = -1;
            for (int s = NUM_SLOTS - 1; s >= 0; s--)
                if (m_occ[s] == 0) fe = s;
            if (fe >= 0) begin
                v  = fe;
                vt = "R8";
            end else begin
                v = m_rr;
                if (m_act == v) v = (v + 1) % NUM_SLOTS;
                m_rr = (v + 1) % NUM_SLOTS;
                vt = "R9";
            end
            m_occ[v] = 0;
            nb = (id % MAX_BLKS) + 1;
            for (int b = 0; b < nb; b++) begin
                int src, dst;
                src = id * MAX_BLKS + b;
                dst = v * SLOT_WORDS + b * BLK_WORDS;
                q_pkt_src.push_back(src);
                q_pkt_dst.push_back(dst);
                q_pkt_tag.push_back(b == 0 ? "R3" : "R5");
                for (int k = 0; k < BLK_WORDS; k++) begin
                    q_wr_addr.push_back(dst + k);
                    q_wr_data.push_back(rdata(src, k));
                end
            end
            q_done_slot.push_back(v);
            q_done_miss.push_back(1'b1);
            q_done_tag.push_back(vt);
            req_valid = 1'b1;
            req_id    = ID_W'(id);
            @(negedge clk);
            req_valid = 1'b0;
            for (int b = 0; b < nb; b++) begin
                int h, s;
                while (q_hdr.size() == 0) @(negedge clk);
                h = q_hdr.pop_front();
                s = q_rsrc.pop_front();
                if (b == 0 && poke >= 0) begin
                    req_valid = 1'b1;
                    req_id    = ID_W'(poke);
                    #1;
                    chk(req_ready == 1'b0, "R6", "ready low during fetch", req_ready, 0);
                    @(negedge clk);
                    req_valid = 1'b0;
                end
                repeat (gap) @(negedge clk);
                resp_valid = 1'b1;
                resp_data  = 32'(h);
                @(negedge clk);
                for (int k = 0; k < BLK_WORDS; k++) begin
                    if ((gap % 2) == 1 && k == 1) begin
                        resp_valid = 1'b0;
                        resp_data  = 32'hDEAD_BEEF;
                        @(negedge clk);
                    end
                    resp_valid = 1'b1;
                    resp_data  = rdata(s, k);
                    @(negedge clk);
                end
                resp_valid = 1'b0;
                resp_data  = '0;
            end
            while (q_done_slot.size() != 0) @(negedge clk);
            m_occ[v] = 1;
            m_id[v]  = id;
            m_act    = v;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            m_occ[s] = 0;
            m_id[s]  = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(done_valid == 1'b0, "R1", "done_valid after reset", done_valid, 0);
        chk(pkt_valid == 1'b0, "R1", "pkt_valid after reset", pkt_valid, 0);
        chk(cw_en == 1'b0, "R1", "cw_en after reset", cw_en, 0);
        @(negedge clk);

        do_req(5, 0, -1);   // empty table, two blocks -> slot 0
        do_req(5, 0, -1);   // hit
        do_req(2, 1, 5);    // three blocks, busy lookup ignored
        do_req(7, 2, -1);   // four blocks
        do_req(8, 0, -1);   // one block, table now full
        do_req(2, 0, -1);   // hit moves the active slot
        do_req(9, 1, -1);   // round-robin eviction
        do_req(12, 0, 9);
        do_req(2, 3, -1);   // evicted id fetched again
        do_req(9, 0, -1);
        do_req(6, 1, -1);
        do_req(9, 0, -1);   // pointer now lands on the active slot
        do_req(4, 0, -1);
        do_req(12, 2, -1);
        do_req(4, 0, -1);
        repeat (4) @(negedge clk);
        chk(q_wr_addr.size() == 0, "R4", "pending writes at end", q_wr_addr.size(), 0);
        chk(q_pkt_src.size() == 0, "R5", "pending requests at end", q_pkt_src.size(), 0);
        finish_run();
    end

endmodule